// File: doc/BRIEF.md
# Pause-Frame Transmit Throttle Controller

This block converts received, already validated flow-control frames into a decision on whether the transmitter may send. The receive path gives it a one-cycle strobe for each accepted pause frame, along with the frame's 16-bit pause-time field. The transmitter gives it a flag that is high while a packet is in flight. A free-running slot-time tick, one pulse per 512 bit times, paces the pause countdown.

A nonzero pause time does three things. It raises the TXOFF status bit, loads the countdown, and stops transmission. Transmission stops at once if the line is idle. If a packet is in progress, it stops only when that packet ends. A pause time of zero acts as a resume (XON) frame: it releases the transmitter immediately and is counted in a saturating XON counter, which software-side logic can clear. None of this happens unless the receive flow-control enable input is high.

Top module: `pause_throttle`

## Requirements
- R1: A frame strobe with `fc_enable` high and a nonzero `frame_time` sets `txoff` on the next clock edge. It also loads the countdown with `frame_time`.
- R2: When the R1 condition occurs while `tx_busy` is high, `tx_allowed` stays high and falls only on the edge after the first cycle in which `tx_busy` is low. When `tx_busy` is low, `tx_allowed` falls on the same edge that sets `txoff`.
- R3: Each accepted nonzero-time frame produces exactly one cycle of `pause_inc`, on the edge after the strobe. `pause_inc` and `xon_inc` are never high together.
- R4: While `txoff` is high, each `slot_tick` decrements the countdown by one. The edge that takes it from 1 to 0 clears `txoff` and raises `tx_allowed`.
- R5: An accepted frame with `frame_time` equal to 0 clears `txoff` and raises `tx_allowed` on the next edge, whatever the state of `tx_busy`.
- R6: Each accepted zero-time frame produces one cycle of `xon_inc`. On the same edge, `xon_count` increases by one.
- R7: While `fc_enable` is low, frame strobes produce no strobe, no count change and no pause. On the first edge with `fc_enable` low, `txoff` is forced low and `tx_allowed` high.
- R8: `xon_count` stops at its all-ones value and does not wrap.
- R9: `xon_clear` zeroes `xon_count` on the next edge, and takes priority over a simultaneous increment.
- R10: A nonzero frame that arrives while already paused reloads the countdown with the new value; it does not add to the remaining count.
- R11: Without `slot_tick`, the countdown does not move, and `txoff` stays high indefinitely.
- R12: After reset, `txoff` is low, `tx_allowed` is high, both strobes are low and `xon_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Receive flow-control enable |
| frame_valid | input | 1 | One-cycle strobe for a validated pause frame |
| frame_time | input | TIME_W | Pause-time field of the strobed frame, in slot times |
| tx_busy | input | 1 | High while a packet is being transmitted |
| slot_tick | input | 1 | One pulse per 512 bit times |
| xon_clear | input | 1 | Synchronous clear of the XON counter |
| tx_allowed | output | 1 | Transmitter may start or continue sending |
| txoff | output | 1 | Pause-in-effect status bit |
| pause_inc | output | 1 | Statistics strobe for a nonzero pause frame |
| xon_inc | output | 1 | Statistics strobe for an XON frame |
| xon_count | output | CNT_W | Saturating count of received XON frames |

## Verification
The bench builds the block with `CNT_W` = 4, so the XON counter reaches its all-ones value of 15 after a short burst of resume frames. This makes the saturation and clear-versus-increment corners cheap to reach. `TIME_W` keeps its default of 16, but the bench uses small pause values with a tick on most cycles, so expiry, reload and deferral can all be seen within tens of cycles. The busy flag is held across pause arrivals to expose the deferred-stop path. The enable input is dropped while paused to check that the forced release works.

// File: rtl/pause_throttle_pkg.sv
package pause_throttle_pkg;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_PAUSE = 2'd1,
        FR_XON   = 2'd2
    } frame_kind_t;

endpackage

// File: rtl/pt_frame_classify.sv
module pt_frame_classify
    import pause_throttle_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              fc_enable,
    input  logic              frame_valid,
    input  logic [TIME_W-1:0] frame_time,
    output frame_kind_t       kind
);
    logic zero_time;

    always_comb begin
        zero_time = (frame_time == '0);
        if (!(frame_valid && fc_enable)) begin
            kind = FR_NONE;
        end else if (zero_time) begin
            kind = FR_XON;
        end else begin
            kind = FR_PAUSE;
        end
    end
endmodule

// File: rtl/pt_pause_core.sv
module pt_pause_core
    import pause_throttle_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_enable,
    input  frame_kind_t       kind,
    input  logic [TIME_W-1:0] frame_time,
    input  logic              tx_busy,
    input  logic              slot_tick,
    output logic              txoff,
    output logic              halted,
    output logic              pause_inc,
    output logic              xon_inc
);
    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    typedef struct packed {
        logic [TIME_W-1:0] remain;
        logic              txoff;
        logic              halted;
        logic              pause_inc;
        logic              xon_inc;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d           = state_q;
        state_d.pause_inc = 1'b0;
        state_d.xon_inc   = 1'b0;

        if (!fc_enable) begin
            state_d.remain = '0;
            state_d.txoff  = 1'b0;
            state_d.halted = 1'b0;
        end else begin
            unique case (kind)
                FR_XON: begin
                    state_d.xon_inc = 1'b1;
                    state_d.remain  = '0;
                    state_d.txoff   = 1'b0;
                    state_d.halted  = 1'b0;
                end
                FR_PAUSE: begin
                    state_d.pause_inc = 1'b1;
                    state_d.remain    = frame_time;
                    state_d.txoff     = 1'b1;
                    state_d.halted    = state_q.halted | ~tx_busy;
                end
                default: begin
                    if (state_q.txoff) begin
                        if (slot_tick && state_q.remain == ONE) begin
                            state_d.remain = '0;
                            state_d.txoff  = 1'b0;
                            state_d.halted = 1'b0;
                        end else begin
                            if (slot_tick) begin
                                state_d.remain = state_q.remain - ONE;
                            end
                            state_d.halted = state_q.halted | ~tx_busy;
                        end
                    end else begin
                        state_d.halted = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign txoff     = state_q.txoff;
    assign halted    = state_q.halted;
    assign pause_inc = state_q.pause_inc;
    assign xon_inc   = state_q.xon_inc;
endmodule

// File: rtl/pt_sat_counter.sv
module pt_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc && count_q != TOP) begin
            count_d = count_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/pause_throttle.sv
module pause_throttle
    import pause_throttle_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_enable,
    input  logic              frame_valid,
    input  logic [TIME_W-1:0] frame_time,
    input  logic              tx_busy,
    input  logic              slot_tick,
    input  logic              xon_clear,
    output logic              tx_allowed,
    output logic              txoff,
    output logic              pause_inc,
    output logic              xon_inc,
    output logic [CNT_W-1:0]  xon_count
);
    frame_kind_t kind;
    logic        halted;
    logic        xon_seen;

    pt_frame_classify #(.TIME_W(TIME_W)) u_classify (
        .fc_enable   (fc_enable),
        .frame_valid (frame_valid),
        .frame_time  (frame_time),
        .kind        (kind)
    );

    pt_pause_core #(.TIME_W(TIME_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .fc_enable  (fc_enable),
        .kind       (kind),
        .frame_time (frame_time),
        .tx_busy    (tx_busy),
        .slot_tick  (slot_tick),
        .txoff      (txoff),
        .halted     (halted),
        .pause_inc  (pause_inc),
        .xon_inc    (xon_inc)
    );

    assign xon_seen = (kind == FR_XON);

    pt_sat_counter #(.W(CNT_W)) u_xon_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (xon_seen),
        .clr   (xon_clear),
        .count (xon_count)
    );

    assign tx_allowed = ~halted;
endmodule

// File: rtl/pt_throttle_checker.sv
module pt_throttle_checker #(
    parameter int TIME_W = 16,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fc_enable,
    input logic              frame_valid,
    input logic [TIME_W-1:0] frame_time,
    input logic              tx_busy,
    input logic              xon_clear,
    input logic              tx_allowed,
    input logic              txoff,
    input logic              pause_inc,
    input logic              xon_inc,
    input logic [CNT_W-1:0]  xon_count
);
    a_r1_pause_sets_txoff: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && fc_enable && frame_time != '0) |=> txoff);

    a_r2_busy_keeps_sending: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_allowed && tx_busy) |=> tx_allowed);

    a_r2_block_implies_txoff: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_allowed |-> txoff);

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pause_inc && xon_inc));

    a_r5_xon_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && fc_enable && frame_time == '0) |=> (!txoff && tx_allowed && xon_inc));

    a_r7_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_enable |=> (!txoff && tx_allowed && !pause_inc && !xon_inc));

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_count == '1 && !xon_clear) |=> xon_count == '1);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        xon_clear |=> xon_count == '0);
endmodule

bind pause_throttle pt_throttle_checker #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fc_enable   (fc_enable),
    .frame_valid (frame_valid),
    .frame_time  (frame_time),
    .tx_busy     (tx_busy),
    .xon_clear   (xon_clear),
    .tx_allowed  (tx_allowed),
    .txoff       (txoff),
    .pause_inc   (pause_inc),
    .xon_inc     (xon_inc),
    .xon_count   (xon_count)
);

// File: tb/pause_throttle_test.sv
module pause_throttle_test;
    localparam int TIME_W = 16;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fc_enable = 1'b0;
    logic              frame_valid = 1'b0;
    logic [TIME_W-1:0] frame_time = '0;
    logic              tx_busy = 1'b0;
    logic              slot_tick = 1'b0;
    logic              xon_clear = 1'b0;
    logic              tx_allowed, txoff, pause_inc, xon_inc;
    logic [CNT_W-1:0]  xon_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pause_throttle #(.TIME_W(TIME_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .frame_valid(frame_valid),
        .frame_time(frame_time), .tx_busy(tx_busy), .slot_tick(slot_tick),
        .xon_clear(xon_clear), .tx_allowed(tx_allowed), .txoff(txoff),
        .pause_inc(pause_inc), .xon_inc(xon_inc), .xon_count(xon_count)
    );

    // behavioural reference
    int m_left = 0;
    bit m_pause = 0, m_block = 0, m_pinc = 0, m_xinc = 0;
    int m_xons = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_pause = 0; m_block = 0; m_pinc = 0; m_xinc = 0; m_xons = 0;
        end else begin
            m_pinc = 0;
            m_xinc = 0;
            if (xon_clear) m_xons = 0;
            else if (fc_enable && frame_valid && frame_time == 0 && m_xons < CMAX) m_xons++;
            if (!fc_enable) begin
                m_pause = 0; m_block = 0; m_left = 0;
            end else if (frame_valid && frame_time == 0) begin
                m_xinc = 1; m_pause = 0; m_block = 0; m_left = 0;
            end else if (frame_valid) begin
                m_pinc = 1; m_pause = 1; m_left = int'(frame_time);
                if (!tx_busy) m_block = 1;
            end else if (m_pause) begin
                if (slot_tick) m_left--;
                if (m_left == 0) begin
                    m_pause = 0; m_block = 0;
                end else if (!tx_busy) begin
                    m_block = 1;
                end
            end
        end
    end

    task automatic chk(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(txoff), int'(m_pause), "R1 txoff vs model");
            chk(int'(tx_allowed), int'(!m_block), "R2 tx_allowed vs model");
            chk(int'(pause_inc), int'(m_pinc), "R3 pause_inc vs model");
            chk(int'(xon_inc), int'(m_xinc), "R6 xon_inc vs model");
            chk(int'(xon_count), m_xons, "R8 xon_count vs model");
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input int t);
        frame_valid = 1'b1;
        frame_time  = TIME_W'(t);
        @(negedge clk);
        frame_valid = 1'b0;
        frame_time  = '0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(int'(txoff), 0, "R12 txoff after reset");
        chk(int'(tx_allowed), 1, "R12 tx_allowed after reset");
        chk(int'(xon_count), 0, "R12 count after reset");
        fc_enable = 1'b1;
        cyc(1);

        // R1/R3/R4: pause 5, idle line, tick every cycle
        slot_tick = 1'b1;
        send(5);
        chk(int'(txoff), 1, "R1 txoff set");
        chk(int'(tx_allowed), 0, "R2 immediate block");
        chk(int'(pause_inc), 1, "R3 pause_inc pulse");
        cyc(4);
        chk(int'(txoff), 1, "R4 still paused before last tick");
        cyc(1);
        chk(int'(txoff), 0, "R4 expiry clears txoff");
        chk(int'(tx_allowed), 1, "R4 expiry resumes");

        // R11: no tick holds pause
        slot_tick = 1'b0;
        send(2);
        cyc(20);
        chk(int'(txoff), 1, "R11 no tick keeps pause");
        slot_tick = 1'b1;
        cyc(3);
        chk(int'(txoff), 0, "R11 ticks then expire");

        // R2: deferred stop while busy
        slot_tick = 1'b0;
        tx_busy = 1'b1;
        send(9);
        chk(int'(tx_allowed), 1, "R2 busy defers stop");
        cyc(3);
        chk(int'(tx_allowed), 1, "R2 still sending");
        tx_busy = 1'b0;
        cyc(1);
        chk(int'(tx_allowed), 0, "R2 stop after packet");

        // R10 reload with smaller value, R5 XON later
        slot_tick = 1'b1;
        send(2);
        cyc(1);
        chk(int'(txoff), 1, "R10 reload keeps pause");
        cyc(1);
        chk(int'(txoff), 0, "R10 reload not additive");
        send(30);
        cyc(2);
        tx_busy = 1'b1;
        send(0);
        chk(int'(txoff), 0, "R5 xon clears txoff");
        chk(int'(tx_allowed), 1, "R5 xon resumes");
        chk(int'(xon_inc), 1, "R6 xon_inc pulse");
        tx_busy = 1'b0;

        // R7 disable while paused and ignore frames
        send(40);
        fc_enable = 1'b0;
        cyc(1);
        chk(int'(txoff), 0, "R7 forced release");
        chk(int'(tx_allowed), 1, "R7 tx allowed");
        send(7);
        send(0);
        chk(int'(xon_count), 1, "R7 disabled frames ignored");
        chk(int'(txoff), 0, "R7 no pause while disabled");
        fc_enable = 1'b1;
        cyc(1);

        // R8 saturation
        for (int k = 0; k < CMAX + 4; k++) send(0);
        chk(int'(xon_count), CMAX, "R8 saturates");
        // R9 clear beats increment
        xon_clear = 1'b1;
        send(0);
        xon_clear = 1'b0;
        chk(int'(xon_count), 0, "R9 clear priority");
        send(0);
        chk(int'(xon_count), 1, "R9 counts after clear");
        cyc(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule